// File: doc/BRIEF.md
# Three-Phase Zero-Sequence Reference Normalizer

This block turns three signed per-phase reference samples into three unsigned compare values for a multilevel modulator. It finds the largest and smallest of the three references and forms a common-mode offset equal to minus half their sum. It adds that offset to every phase to get a pole reference. It then scales each pole reference against the DC-link voltage so that the result spans zero to twice the carrier period. The offset lets the peak phase reference rise to about 1.15 (2/√3) of half the DC-link voltage before any pole reference leaves the linear range. The two-period output span suits a modulator that folds each value into two carrier-wide bands.

A single-cycle `inValid` pulse presents the samples. The scaling needs a division by the DC-link voltage, done bit-serially in three parallel restoring dividers, so the results appear a fixed number of cycles later together with a single-cycle `outValid` pulse. While a conversion runs, `busy` is high and new samples are refused.

Top module: `zsn_normalizer`

## Requirements
- R1: While reset is held and right after it is released, `outValid` and `busy` are 0 and all three compare outputs are 0.
- R2: For an accepted input, `outValid` is high for exactly one cycle, and it rises on the rising edge that comes DW+PW+4 edges after the accepting edge (36 with default parameters).
- R3: An `inValid` pulse is accepted only when `busy` is low. `busy` is high from the accepting edge until the edge where `outValid` rises. An `inValid` pulse during `busy` produces no result and does not change the pending result.
- R4: With P the period input and V the DC-link input, each output equals P + trunc((2·ref_x − max − min)·P / V), where the quotient is truncated toward zero. This is the scaled value of ref_x plus the offset −(max+min)/2, so a phase B lagging by 120° and a phase C leading by 120° are treated the same as phase A.
- R5: Ties between references have no effect. A zero pole reference maps exactly to P, so three equal references give P on every output.
- R6: Every output saturates into the range 0 to 2·P. A positive pole reference beyond the linear range gives 2·P, and a negative one gives 0.
- R7: A DC-link input of zero or below gives P on every output.
- R8: Between results, the compare outputs keep the last result unchanged.
- R9: At every result, the largest output plus the smallest output equals 2·P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | One-cycle strobe that presents a new sample set |
| refA | input | DW (16) | Phase A reference, two's complement |
| refB | input | DW (16) | Phase B reference, two's complement |
| refC | input | DW (16) | Phase C reference, two's complement |
| vdc | input | DW (16) | DC-link voltage, two's complement, same scale as the references |
| period | input | PW (16) | Carrier period, unsigned |
| busy | output | 1 | High while a conversion is in progress |
| outValid | output | 1 | One-cycle strobe that marks new compare values |
| cmpA | output | PW+1 (17) | Phase A compare value, 0 to 2·period |
| cmpB | output | PW+1 (17) | Phase B compare value, 0 to 2·period |
| cmpC | output | PW+1 (17) | Phase C compare value, 0 to 2·period |

## Verification
The bench builds the block with its default widths of 16-bit samples and a 16-bit period. This gives 34-step dividers and a 36-cycle latency. At these widths the bench can drive full-scale references of opposite sign together with a period of 65535. That pushes the numerator to its widest value and the output to the top of its 17-bit range. A real sine sweep at a modulation index of 1.15 with a realistic period shows that the offset keeps every value inside the linear range. Small DC-link values, a zero period and a nonpositive DC-link reach the saturation and guard paths.

// File: rtl/zsn_pkg.sv
package zsn_pkg;

  localparam int PHASES = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_DIV,
    ST_DONE
  } zsnState_e;

  // strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic capture;  // latch the input sample set
    logic prep;     // offset, magnitude, divider load
    logic step;     // one restoring-division iteration
    logic finish;   // saturate and register results
  } zsnStrobe_t;

endpackage

// File: rtl/zsn_ctrl.sv
module zsn_ctrl
  import zsn_pkg::*;
#(
  parameter int STEPS = 34
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       busy,
  output zsnStrobe_t strobe
);

  localparam int CNTW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(STEPS - 1);

  zsnState_e stateR;
  logic [CNTW-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR  <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (stateR)
        ST_IDLE: if (inValid) stateR <= ST_PREP;
        ST_PREP: begin
          stateR  <= ST_DIV;
          stepCnt <= '0;
        end
        ST_DIV: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST) stateR <= ST_DONE;
        end
        default: stateR <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture = (stateR == ST_IDLE) && inValid;
    strobe.prep    = (stateR == ST_PREP);
    strobe.step    = (stateR == ST_DIV);
    strobe.finish  = (stateR == ST_DONE);
  end

  assign busy = (stateR != ST_IDLE);

endmodule

// File: rtl/zsn_div_lane.sv
module zsn_div_lane #(
  parameter int NW  = 34,
  parameter int DVW = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           load,
  input  logic           step,
  input  logic [NW-1:0]  numIn,
  input  logic [DVW-1:0] divIn,
  output logic [NW-1:0]  quo
);

  logic [DVW-1:0] remR;
  logic [DVW-1:0] dvR;
  logic [NW-1:0]  quoR;
  logic [DVW:0]   shifted;
  logic           fits;

  assign shifted = {remR, quoR[NW-1]};
  assign fits    = (shifted >= {1'b0, dvR});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remR <= '0;
      dvR  <= '0;
      quoR <= '0;
    end else if (load) begin
      remR <= '0;
      dvR  <= divIn;
      quoR <= numIn;
    end else if (step) begin
      remR <= DVW'(fits ? (shifted - {1'b0, dvR}) : shifted);
      quoR <= {quoR[NW-2:0], fits};
    end
  end

  assign quo = quoR;

endmodule

// File: rtl/zsn_datapath.sv
module zsn_datapath
  import zsn_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  zsnStrobe_t           strobe,
  input  logic signed [DW-1:0] refA,
  input  logic signed [DW-1:0] refB,
  input  logic signed [DW-1:0] refC,
  input  logic signed [DW-1:0] vdc,
  input  logic [PW-1:0]        period,
  output logic                 outValid,
  output logic [PW:0]          cmpA,
  output logic [PW:0]          cmpB,
  output logic [PW:0]          cmpC
);

  localparam int NW = DW + PW + 2;
  localparam int CW = PW + 1;

  logic signed [DW-1:0] refIn [PHASES];
  logic signed [DW-1:0] refR  [PHASES];
  logic signed [DW-1:0] vdcR;
  logic [PW-1:0]        perR;
  logic                 negR  [PHASES];
  logic [CW-1:0]        cmpR  [PHASES];
  logic                 validR;

  logic signed [DW-1:0] hiRef, loRef;
  logic                 vdcBad;
  logic [DW-1:0]        divisor;

  always_comb begin
    refIn[0] = refA;
    refIn[1] = refB;
    refIn[2] = refC;
  end

  // extremes; on ties the first one found is kept, value identical either way
  always_comb begin
    hiRef = refR[0];
    loRef = refR[0];
    for (int i = 1; i < PHASES; i++) begin
      if (refR[i] > hiRef) hiRef = refR[i];
      if (refR[i] < loRef) loRef = refR[i];
    end
  end

  assign vdcBad  = vdcR[DW-1] || (vdcR == '0);
  assign divisor = vdcBad ? DW'(1) : $unsigned(vdcR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vdcR <= '0;
      perR <= '0;
      for (int i = 0; i < PHASES; i++) refR[i] <= '0;
    end else if (strobe.capture) begin
      vdcR <= vdc;
      perR <= period;
      for (int i = 0; i < PHASES; i++) refR[i] <= refIn[i];
    end
  end

  for (genvar g = 0; g < PHASES; g++) begin : g_lane
    logic signed [DW+1:0] pole2;    // twice the pole reference
    logic [DW+1:0]        mag;
    logic [NW-1:0]        num;
    logic [NW-1:0]        quo;
    logic                 over;
    logic [PW-1:0]        qLo;
    logic [CW-1:0]        cmpNext;

    assign pole2 = {refR[g][DW-1], refR[g], 1'b0}
                 - {{2{hiRef[DW-1]}}, hiRef}
                 - {{2{loRef[DW-1]}}, loRef};
    assign mag   = pole2[DW+1] ? $unsigned(-pole2) : $unsigned(pole2);
    assign num   = vdcBad ? '0 : (NW'(mag) * NW'(perR));

    zsn_div_lane #(.NW(NW), .DVW(DW)) i_div (
      .clk   (clk),
      .rstN  (rstN),
      .load  (strobe.prep),
      .step  (strobe.step),
      .numIn (num),
      .divIn (divisor),
      .quo   (quo)
    );

    assign over = (quo > NW'(perR));
    assign qLo  = quo[PW-1:0];

    always_comb begin
      if (over)
        cmpNext = negR[g] ? '0 : {perR, 1'b0};
      else if (negR[g])
        cmpNext = {1'b0, perR} - {1'b0, qLo};
      else
        cmpNext = {1'b0, perR} + {1'b0, qLo};
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        negR[g] <= 1'b0;
        cmpR[g] <= '0;
      end else begin
        if (strobe.prep)   negR[g] <= pole2[DW+1];
        if (strobe.finish) cmpR[g] <= cmpNext;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) validR <= 1'b0;
    else       validR <= strobe.finish;
  end

  assign outValid = validR;
  assign cmpA     = cmpR[0];
  assign cmpB     = cmpR[1];
  assign cmpC     = cmpR[2];

endmodule

// File: rtl/zsn_normalizer.sv
module zsn_normalizer
  import zsn_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic signed [DW-1:0] refA,
  input  logic signed [DW-1:0] refB,
  input  logic signed [DW-1:0] refC,
  input  logic signed [DW-1:0] vdc,
  input  logic [PW-1:0]        period,
  output logic                 busy,
  output logic                 outValid,
  output logic [PW:0]          cmpA,
  output logic [PW:0]          cmpB,
  output logic [PW:0]          cmpC
);

  localparam int STEPS = DW + PW + 2;

  zsnStrobe_t strobe;

  zsn_ctrl #(.STEPS(STEPS)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .busy    (busy),
    .strobe  (strobe)
  );

  zsn_datapath #(.DW(DW), .PW(PW)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .refA     (refA),
    .refB     (refB),
    .refC     (refC),
    .vdc      (vdc),
    .period   (period),
    .outValid (outValid),
    .cmpA     (cmpA),
    .cmpB     (cmpB),
    .cmpC     (cmpC)
  );

endmodule

// File: rtl/zsn_normalizer_chk.sv
module zsn_normalizer_chk #(
  parameter int DW = 16,
  parameter int PW = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic signed [DW-1:0] refA,
  input logic signed [DW-1:0] refB,
  input logic signed [DW-1:0] refC,
  input logic signed [DW-1:0] vdc,
  input logic [PW-1:0]        period,
  input logic                 busy,
  input logic                 outValid,
  input logic [PW:0]          cmpA,
  input logic [PW:0]          cmpB,
  input logic [PW:0]          cmpC
);

  localparam int LAT = DW + PW + 4;

  logic [15:0]   latCnt;
  logic [PW-1:0] perReg;
  logic [PW:0]   hiC, loC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latCnt <= '0;
      perReg <= '0;
    end else if (inValid && !busy) begin
      latCnt <= 16'd1;
      perReg <= period;
    end else if (latCnt != '0 && latCnt != 16'hFFFF) begin
      latCnt <= latCnt + 16'd1;
    end
  end

  always_comb begin
    hiC = cmpA;
    loC = cmpA;
    if (cmpB > hiC) hiC = cmpB;
    if (cmpC > hiC) hiC = cmpC;
    if (cmpB < loC) loC = cmpB;
    if (cmpC < loC) loC = cmpC;
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (latCnt == 16'(LAT + 1)));

  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !busy) |=> busy);

  a_r3_busy_ends_at_result: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> outValid);

  a_r6_within_range: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (cmpA <= {perReg, 1'b0} && cmpB <= {perReg, 1'b0}
                  && cmpC <= {perReg, 1'b0}));

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable({cmpA, cmpB, cmpC}));

  a_r9_extremes_sum: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ({1'b0, hiC} + {1'b0, loC} == {1'b0, perReg, 1'b0}));

endmodule

bind zsn_normalizer zsn_normalizer_chk #(.DW(DW), .PW(PW)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .refA     (refA),
  .refB     (refB),
  .refC     (refC),
  .vdc      (vdc),
  .period   (period),
  .busy     (busy),
  .outValid (outValid),
  .cmpA     (cmpA),
  .cmpB     (cmpB),
  .cmpC     (cmpC)
);

// File: tb/test_zsn_normalizer.sv
module test_zsn_normalizer;

  localparam int DW  = 16;
  localparam int PW  = 16;
  localparam int LAT = DW + PW + 4;

  typedef struct {
    int    ea, eb, ec;
    int    per;
    int    due;
    string tag;
  } item_t;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic signed [DW-1:0] refA = '0, refB = '0, refC = '0, vdc = '0;
  logic [PW-1:0]        period = '0;
  logic                 busy, outValid;
  logic [PW:0]          cmpA, cmpB, cmpC;

  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;
  item_t sb[$];
  int    lastA, lastB, lastC;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  zsn_normalizer #(.DW(DW), .PW(PW)) i_zsn_normalizer (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .refA(refA), .refB(refB), .refC(refC), .vdc(vdc), .period(period),
    .busy(busy), .outValid(outValid), .cmpA(cmpA), .cmpB(cmpB), .cmpC(cmpC)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int expCmp(input int r, input int mx, input int mn,
                                input int v, input int p);
    longint p2, mag, q;
    if (v <= 0) return p;
    p2  = longint'(2 * r - mx - mn);
    mag = (p2 < 0) ? -p2 : p2;
    q   = (mag * longint'(p)) / longint'(v);
    if (q > longint'(p)) q = longint'(p);
    return (p2 < 0) ? p - int'(q) : p + int'(q);
  endfunction

  task automatic send(input int a, input int b, input int c, input int v,
                      input int p, input string tag);
    item_t it;
    int mx, mn;
    @(negedge clk);
    while (busy) @(negedge clk);
    mx = (a > b) ? a : b; mx = (c > mx) ? c : mx;
    mn = (a < b) ? a : b; mn = (c < mn) ? c : mn;
    it.ea  = expCmp(a, mx, mn, v, p);
    it.eb  = expCmp(b, mx, mn, v, p);
    it.ec  = expCmp(c, mx, mn, v, p);
    it.per = p;
    it.due = cyc + 1 + LAT;
    it.tag = tag;
    sb.push_back(it);
    refA = DW'(a); refB = DW'(b); refC = DW'(c); vdc = DW'(v); period = PW'(p);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(busy == 1'b1, "R3 busy after accept", int'(busy), 1);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3 result with no accepted input", 1, 0);
      end else begin
        item_t it;
        int hi, lo;
        it = sb.pop_front();
        check(cyc == it.due, {"R2 latency ", it.tag}, cyc, it.due);
        check(int'(cmpA) == it.ea, {it.tag, " phase A"}, int'(cmpA), it.ea);
        check(int'(cmpB) == it.eb, {it.tag, " phase B"}, int'(cmpB), it.eb);
        check(int'(cmpC) == it.ec, {it.tag, " phase C"}, int'(cmpC), it.ec);
        hi = int'(cmpA); lo = int'(cmpA);
        if (int'(cmpB) > hi) hi = int'(cmpB);
        if (int'(cmpC) > hi) hi = int'(cmpC);
        if (int'(cmpB) < lo) lo = int'(cmpB);
        if (int'(cmpC) < lo) lo = int'(cmpC);
        check(hi + lo == 2 * it.per, {"R9 extremes ", it.tag}, hi + lo, 2 * it.per);
        lastA = int'(cmpA); lastB = int'(cmpB); lastC = int'(cmpC);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid && !busy, "R1 flags in reset", int'({busy, outValid}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !busy, "R1 flags after reset", int'({busy, outValid}), 0);
    check(cmpA == '0 && cmpB == '0 && cmpC == '0, "R1 outputs after reset",
          int'(cmpA) + int'(cmpB) + int'(cmpC), 0);

    send(0, 0, 0, 20000, 1667, "R5 zero refs");
    send(1000, 1000, 1000, 20000, 1667, "R5 equal refs");
    send(500, 500, -1000, 20000, 1667, "R5 tied maxima");
    send(-700, 300, -700, 8000, 1000, "R5 tied minima");

    for (int k = 0; k < 12; k++) begin
      real th;
      th = 2.0 * 3.14159265358979 * k / 12.0;
      send($rtoi(11500.0 * $sin(th)),
           $rtoi(11500.0 * $sin(th - 2.0 * 3.14159265358979 / 3.0)),
           $rtoi(11500.0 * $sin(th + 2.0 * 3.14159265358979 / 3.0)),
           20000, 1667, "R4 sine sweep");
    end

    send(30000, -30000, 0, 1000, 1667, "R6 overmodulation");
    send(-20000, 5000, 25000, 300, 4000, "R6 overmodulation mixed");
    send(32767, -32768, 0, 32767, 65535, "R6 full scale");
    send(1234, -4321, 999, 0, 1667, "R7 zero vdc");
    send(1234, -4321, 999, -500, 1667, "R7 negative vdc");
    send(800, -300, 50, 5000, 0, "R4 zero period");

    // inputs presented while busy must be refused
    send(2000, -1500, 100, 12000, 2500, "R3 pending result");
    for (int k = 0; k < 5; k++) begin
      refA = 16'sd9999; refB = -16'sd9999; refC = 16'sd0; vdc = 16'sd10;
      period = 16'd77;
      inValid = 1'b1;
      @(negedge clk);
      inValid = 1'b0;
      @(negedge clk);
    end
    drain();

    // outputs hold between results
    begin
      int hA, hB, hC;
      hA = int'(cmpA); hB = int'(cmpB); hC = int'(cmpC);
      check(hA == lastA && hB == lastB && hC == lastC, "R8 hold at drain",
            hA + hB + hC, lastA + lastB + lastC);
      repeat (20) @(negedge clk);
      check(int'(cmpA) == hA, "R8 hold phase A", int'(cmpA), hA);
      check(int'(cmpB) == hB, "R8 hold phase B", int'(cmpB), hB);
      check(int'(cmpC) == hC, "R8 hold phase C", int'(cmpC), hC);
    end
    check(!busy && !outValid, "R3 idle after drain", int'({busy, outValid}), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule